// File: doc/BRIEF.md
# Asynchronous External Memory Bus Interface

This block lets a 16-bit processor core reach external asynchronous SRAM or ROM. The external memory is split into a program space and a data space, and each has its own active-low select line. The core presents a request with an address, a space flag and write data. The block then runs one strobed bus cycle and gives back a single completion pulse. On a read, the captured word comes back in the same cycle as that pulse.

Each access has four phases:
- **Setup:** the address and the select for the chosen space are driven one clock before the strobe falls.
- **Strobe low:** the read or write strobe stays low for 1 + N clocks. N is a 2-bit wait-state count taken from a configuration input when the request is accepted.
- **Strobe high:** the strobe rises.
- **Hold:** the address and select are held for one more clock.

The bidirectional data bus is modelled as three signals: a separate output word, an input word and an output enable. The write strobe being low is what turns the data bus into an output. The read strobe being low turns it into an input.

While reset is high, every control output is marked released through a control-enable output, and the data bus is not driven. A new request is held off by `req_ready` until the bus returns to idle.

Top module: `async_mem_bus`

## Requirements
- R1: While `rst` is high, `bus_ctl_en`, `bus_dout_en`, `rsp_done` and `req_ready` are 0, and both strobes and both selects are 1. On the first clock after `rst` falls, `bus_ctl_en` and `req_ready` become 1.
- R2: An access with `req_space` = 1 (program space) drives `bus_prog_sel_n` low and keeps `bus_data_sel_n` high throughout.
- R3: An access with `req_space` = 0 (data space) drives `bus_data_sel_n` low and keeps `bus_prog_sel_n` high throughout.
- R4: While `bus_wr_strb_n` is low, `bus_dout_en` is 1, `bus_dout` equals the request's write data, and `bus_rd_strb_n` is high. `bus_dout_en` is never 1 while `bus_wr_strb_n` is high.
- R5: While `bus_rd_strb_n` is low, `bus_dout_en` is 0. The read word is the value on `bus_din` in the last clock before the read strobe returns high.
- R6: When idle, both strobes and both selects are high and `bus_dout_en` is 0.
- R7: The address and select are valid one clock before a strobe falls and for one clock after it rises. `bus_addr` does not change while a strobe is low.
- R8: The strobe stays low for exactly 1 + N clocks. N is the value of `cfg_wait` in the cycle the request is accepted; later changes to `cfg_wait` do not affect that access.
- R9: The two strobes are never low together. `req_ready` is 0 from acceptance until the access completes, so a request that is held meanwhile is taken only after the current access ends, and then with its own address and space.
- R10: Each access produces exactly one single-cycle `rsp_done` pulse, in the clock after the strobe rises. For a read, `rsp_rdata` holds the captured word in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wait | input | 2 | Wait-state count N, sampled when a request is accepted |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 1 | 1 = program space, 0 = data space |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read word |
| bus_ctl_en | output | 1 | Control pins driven (0 = released) |
| bus_addr | output | 16 | External address |
| bus_prog_sel_n | output | 1 | Program-space select, active low |
| bus_data_sel_n | output | 1 | Data-space select, active low |
| bus_rd_strb_n | output | 1 | Read strobe, active low |
| bus_wr_strb_n | output | 1 | Write strobe, active low |
| bus_dout | output | 16 | Data bus output value |
| bus_dout_en | output | 1 | Data bus output enable |
| bus_din | input | 16 | Data bus input value |

## Verification
The following are checked every cycle by properties:
- the two strobes are never low together;
- the data bus is driven exactly while the write strobe is low;
- exactly one select is low while a strobe is low;
- the address and select are in place on both sides of a strobe, and the address is steady while a strobe is low;
- the strobe width matches the wait count latched at acceptance;
- `rsp_done` follows the strobe rise and lasts a single cycle.

Other behaviour can only be shown by the bench's scenarios, because it depends on values chosen outside the block:
- which select goes low for a given space flag;
- the exact write word on the bus;
- that the read word is the one present just before the strobe rises;
- that a request held during a busy access comes out afterwards with its own address;
- the reset and idle states.

// File: rtl/amb_pkg.sv
package amb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } amb_phase_e;

  localparam int unsigned SPACE_DATA = 0;
  localparam int unsigned SPACE_PROG = 1;
  localparam int unsigned NUM_SPACES = 2;
endpackage

// File: rtl/amb_timing.sv
module amb_timing #(
  parameter int unsigned WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WAIT_W-1:0] wait_n,
  output logic              idle,
  output logic              go_low,
  output logic              go_high,
  output logic              finish
);
  import amb_pkg::*;

  amb_phase_e        phase;
  logic [WAIT_W-1:0] wait_q;
  logic [WAIT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      wait_q <= '0;
      remain <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase  <= PH_SETUP;
            wait_q <= wait_n;
          end
        end
        PH_SETUP: begin
          phase  <= PH_STROBE;
          remain <= wait_q;
        end
        PH_STROBE: begin
          if (remain == '0) phase <= PH_HOLD;
          else              remain <= remain - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Phase decodes that step the pin registers
  assign idle    = (phase == PH_IDLE);
  assign go_low  = (phase == PH_SETUP);
  assign go_high = (phase == PH_STROBE) && (remain == '0);
  assign finish  = (phase == PH_HOLD);
endmodule

// File: rtl/amb_pins.sv
module amb_pins #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              write,
  input  logic              space,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              go_low,
  input  logic              go_high,
  input  logic              finish,
  input  logic [DATA_W-1:0] din,
  output logic              ctl_en,
  output logic [ADDR_W-1:0] addr_q,
  output logic [amb_pkg::NUM_SPACES-1:0] sel_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  import amb_pkg::*;

  logic is_write;

  // Address, write data and strobe registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en   <= 1'b0;
      addr_q   <= '0;
      dout     <= '0;
      is_write <= 1'b0;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      dout_en  <= 1'b0;
      done     <= 1'b0;
      rdata    <= '0;
    end else begin
      ctl_en <= 1'b1;
      done   <= 1'b0;
      if (accept) begin
        addr_q   <= addr_in;
        dout     <= wdata_in;
        is_write <= write;
      end
      if (go_low) begin
        if (is_write) begin
          wr_n    <= 1'b0;
          dout_en <= 1'b1;
        end else begin
          rd_n <= 1'b0;
        end
      end
      if (go_high) begin
        rd_n    <= 1'b1;
        wr_n    <= 1'b1;
        dout_en <= 1'b0;
        done    <= 1'b1;
        if (!is_write) rdata <= din;
      end
    end
  end

  // One select register per address space
  for (genvar gi = 0; gi < NUM_SPACES; gi++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst)         sel_n[gi] <= 1'b1;
      else if (accept) sel_n[gi] <= (32'(space) != gi);
      else if (finish) sel_n[gi] <= 1'b1;
    end
  end
endmodule

// File: rtl/async_mem_bus.sv
module async_mem_bus #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_space,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_ctl_en,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_prog_sel_n,
  output logic              bus_data_sel_n,
  output logic              bus_rd_strb_n,
  output logic              bus_wr_strb_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  input  logic [DATA_W-1:0] bus_din
);
  import amb_pkg::*;

  logic                  idle, go_low, go_high, finish, accept;
  logic [NUM_SPACES-1:0] sel_n;

  assign req_ready = idle && bus_ctl_en;
  assign accept    = req_valid && req_ready;

  amb_timing #(.WAIT_W(WAIT_W)) u_timing (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .wait_n  (cfg_wait),
    .idle    (idle),
    .go_low  (go_low),
    .go_high (go_high),
    .finish  (finish)
  );

  amb_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .write    (req_write),
    .space    (req_space),
    .addr_in  (req_addr),
    .wdata_in (req_wdata),
    .go_low   (go_low),
    .go_high  (go_high),
    .finish   (finish),
    .din      (bus_din),
    .ctl_en   (bus_ctl_en),
    .addr_q   (bus_addr),
    .sel_n    (sel_n),
    .rd_n     (bus_rd_strb_n),
    .wr_n     (bus_wr_strb_n),
    .dout     (bus_dout),
    .dout_en  (bus_dout_en),
    .done     (rsp_done),
    .rdata    (rsp_rdata)
  );

  assign bus_prog_sel_n = sel_n[SPACE_PROG];
  assign bus_data_sel_n = sel_n[SPACE_DATA];
endmodule

// File: rtl/async_mem_bus_checker.sv
module async_mem_bus_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WAIT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [WAIT_W-1:0] cfg_wait,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_prog_sel_n,
  input logic              bus_data_sel_n,
  input logic              bus_rd_strb_n,
  input logic              bus_wr_strb_n,
  input logic              bus_dout_en
);
  localparam int unsigned CNT_W = WAIT_W + 2;

  logic             strb_hi;
  logic             any_sel;
  logic [CNT_W-1:0] low_cnt;
  logic [WAIT_W-1:0] wait_seen;

  assign strb_hi = bus_rd_strb_n && bus_wr_strb_n;
  assign any_sel = !(bus_prog_sel_n && bus_data_sel_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt   <= '0;
      wait_seen <= '0;
    end else begin
      if (req_valid && req_ready) wait_seen <= cfg_wait;
      if (!strb_hi) low_cnt <= low_cnt + 1'b1;
      else          low_cnt <= '0;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_strb_n && !bus_wr_strb_n)); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb_hi |-> !req_ready); // R9
  AST_WR_DRIVES: assert property (@(posedge clk) disable iff (rst)
    bus_dout_en == !bus_wr_strb_n); // R4
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_strb_n |-> !bus_dout_en); // R5
  AST_ONE_SPACE: assert property (@(posedge clk) disable iff (rst)
    !strb_hi |-> ($countones({bus_prog_sel_n, bus_data_sel_n}) == 1)); // R2
  AST_SETUP: assert property (@(posedge clk) disable iff (rst)
    $fell(strb_hi) |-> $past(any_sel)); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(strb_hi) |-> any_sel); // R7
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!strb_hi && $past(!strb_hi)) |-> $stable(bus_addr)); // R7
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(strb_hi) |-> (low_cnt == CNT_W'(wait_seen) + 1'b1)); // R8
  AST_DONE_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(strb_hi) |-> rsp_done); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R10
endmodule

bind async_mem_bus async_mem_bus_checker #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cfg_wait       (cfg_wait),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .rsp_done       (rsp_done),
  .bus_addr       (bus_addr),
  .bus_prog_sel_n (bus_prog_sel_n),
  .bus_data_sel_n (bus_data_sel_n),
  .bus_rd_strb_n  (bus_rd_strb_n),
  .bus_wr_strb_n  (bus_wr_strb_n),
  .bus_dout_en    (bus_dout_en)
);

// File: tb/tb_async_mem_bus.sv
module tb_async_mem_bus;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  cfg_wait;
  logic        req_valid, req_ready, req_write, req_space;
  logic [15:0] req_addr, req_wdata;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        bus_ctl_en;
  logic [15:0] bus_addr;
  logic        bus_prog_sel_n, bus_data_sel_n, bus_rd_strb_n, bus_wr_strb_n;
  logic [15:0] bus_dout;
  logic        bus_dout_en;
  logic [15:0] bus_din;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  async_mem_bus dut (
    .clk(clk), .rst(rst), .cfg_wait(cfg_wait),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_ctl_en(bus_ctl_en),
    .bus_addr(bus_addr), .bus_prog_sel_n(bus_prog_sel_n),
    .bus_data_sel_n(bus_data_sel_n), .bus_rd_strb_n(bus_rd_strb_n),
    .bus_wr_strb_n(bus_wr_strb_n), .bus_dout(bus_dout),
    .bus_dout_en(bus_dout_en), .bus_din(bus_din)
  );

  // Memory model: content depends on address and space; a poison value when not read
  function automatic logic [15:0] mem_word(input logic [15:0] a, input logic sp);
    return a ^ (sp ? 16'hA5A5 : 16'h5A5A);
  endfunction

  assign bus_din = !bus_rd_strb_n ? mem_word(bus_addr, !bus_prog_sel_n) : 16'hDEAD;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(bus_ctl_en == 0 && bus_dout_en == 0 && rsp_done == 0 && req_ready == 0,
        "R1 released in reset", {bus_ctl_en, bus_dout_en, rsp_done, req_ready}, 0);
    chk(bus_rd_strb_n && bus_wr_strb_n && bus_prog_sel_n && bus_data_sel_n,
        "R1 strobes/selects high in reset",
        {bus_rd_strb_n, bus_wr_strb_n, bus_prog_sel_n, bus_data_sel_n}, 4'hF);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_ctl_en && req_ready, "R1 enabled after reset", {bus_ctl_en, req_ready}, 2'b11);
    chk(bus_rd_strb_n && bus_wr_strb_n && bus_prog_sel_n && bus_data_sel_n && !bus_dout_en,
        "R6 idle after reset",
        {bus_rd_strb_n, bus_wr_strb_n, bus_prog_sel_n, bus_data_sel_n, bus_dout_en}, 5'h1E);
  endtask

  task automatic do_access(input bit wr, input bit sp, input logic [15:0] a,
                           input logic [15:0] wd, input logic [1:0] n);
    int lowcnt = 0, done_cnt = 0, bad_sel = 0, bad_dat = 0, bad_busy = 0, bad_addr = 0;
    bit setup_ok, hold_ok = 0, seen_done = 0;
    logic [15:0] got = '0;
    logic own_n, other_n;
    string sreq = sp ? "R2" : "R3";
    chk(req_ready, "R9 ready before access", req_ready, 1);
    cfg_wait = n; req_write = wr; req_space = sp; req_addr = a; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_wait = ~n;
    own_n = sp ? bus_prog_sel_n : bus_data_sel_n;
    setup_ok = !own_n && bus_rd_strb_n && bus_wr_strb_n && bus_addr == a;
    chk(setup_ok, "R7 setup before strobe", {own_n, bus_rd_strb_n, bus_wr_strb_n}, 3'b011);
    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      own_n   = sp ? bus_prog_sel_n : bus_data_sel_n;
      other_n = sp ? bus_data_sel_n : bus_prog_sel_n;
      if (seen_done) begin
        chk(bus_rd_strb_n && bus_wr_strb_n && bus_prog_sel_n && bus_data_sel_n &&
            !bus_dout_en && req_ready, "R6 idle after access",
            {bus_rd_strb_n, bus_wr_strb_n, bus_prog_sel_n, bus_data_sel_n,
             bus_dout_en, req_ready}, 6'h3D);
        break;
      end
      if (!other_n) bad_sel++;
      if (!bus_rd_strb_n || !bus_wr_strb_n) begin
        lowcnt++;
        if (own_n) bad_sel++;
        if (bus_addr != a) bad_addr++;
        if (req_ready) bad_busy++;
        if (wr) begin
          if (bus_wr_strb_n || !bus_rd_strb_n || !bus_dout_en || bus_dout != wd) bad_dat++;
        end else begin
          if (bus_rd_strb_n || !bus_wr_strb_n || bus_dout_en) bad_dat++;
        end
      end else if (bus_dout_en) bad_dat++;
      if (rsp_done) begin
        done_cnt++;
        seen_done = 1;
        hold_ok = !own_n && bus_rd_strb_n && bus_wr_strb_n && bus_addr == a;
        got = rsp_rdata;
        if (req_ready) bad_busy++;
      end
    end
    chk(bad_sel == 0, {sreq, " select for space"}, bad_sel, 0);
    chk(bad_addr == 0, "R7 address steady in strobe", bad_addr, 0);
    chk(hold_ok, "R7 hold after strobe", hold_ok, 1);
    chk(lowcnt == n + 1, "R8 strobe width", lowcnt, n + 1);
    chk(bad_dat == 0, wr ? "R4 write data drive" : "R5 read bus released", bad_dat, 0);
    chk(bad_busy == 0, "R9 ready low while busy", bad_busy, 0);
    chk(done_cnt == 1, "R10 single done", done_cnt, 1);
    if (!wr) chk(got == mem_word(a, sp), "R5 R10 read data", got, mem_word(a, sp));
  endtask

  task automatic test_busy();
    int low_run = 0;
    int guard = 0;
    bit strobe_seen = 0, sel_ok = 0;
    logic [15:0] got = '0, seen_addr = '0;
    cfg_wait = 2'd1; req_write = 1'b0; req_space = 1'b0; req_addr = 16'h0100;
    req_wdata = 16'h0; req_valid = 1'b1;
    @(negedge clk);
    req_space = 1'b1; req_addr = 16'h0200;
    for (int s = 0; s < 20; s++) begin
      if (req_ready) break;
      low_run++;
      @(negedge clk);
    end
    chk(low_run == 4, "R9 held request waits for completion", low_run, 4);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done && guard < 20) begin
      if (!bus_rd_strb_n && !strobe_seen) begin
        strobe_seen = 1;
        seen_addr = bus_addr;
        sel_ok = !bus_prog_sel_n && bus_data_sel_n;
      end
      guard++;
      @(negedge clk);
    end
    got = rsp_rdata;
    chk(seen_addr == 16'h0200 && sel_ok, "R9 held request uses own address",
        seen_addr, 16'h0200);
    chk(got == mem_word(16'h0200, 1'b1), "R9 held request data", got,
        mem_word(16'h0200, 1'b1));
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_wait = '0; req_valid = 1'b0; req_write = 1'b0;
    req_space = 1'b0; req_addr = '0; req_wdata = '0;
    test_reset();
    do_access(1'b1, 1'b1, 16'h1234, 16'hBEEF, 2'd0);
    do_access(1'b1, 1'b0, 16'h00FF, 16'h5AA5, 2'd3);
    do_access(1'b0, 1'b0, 16'h4321, 16'h0000, 2'd1);
    do_access(1'b0, 1'b1, 16'hFFFE, 16'h0000, 2'd2);
    do_access(1'b0, 1'b0, 16'h0000, 16'h0000, 2'd0);
    test_busy();
    do_access(1'b1, 1'b0, 16'h8001, 16'h0001, 2'd3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule